// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing half of a byte-addressed serial memory. It watches the two-wire clock and data lines with a fast system clock, detects START and STOP, and receives a select byte. A fixed prefix and a set of strap pins decide whether the select byte matches. After a match it either accepts a word address and data bytes (write) or shifts out array bytes (read), with an acknowledge on the ninth clock of each byte. It drives the data line only through an open-drain pull-low enable.

Received data bytes go one at a time to a page write buffer outside the block, and a STOP after accepted data starts the array's programming cycle. While that cycle runs, the array reports busy. The controller then refuses its select byte, so the master can poll until the write is done. Read data comes from an asynchronous array read port addressed by the internal address counter. As the array grows beyond 256 bytes, the low middle bits of the select byte carry the upper address bits instead of strap values.

Top module: `i2c_mem_slave`

## Requirements
- R1: A START (data falling while clock is high) restarts select-byte reception from any state, including the middle of a byte. A STOP (data rising while clock is high) returns the block to idle. In idle, bytes sent without a START get no acknowledge.
- R2: The select byte is received MSB first. Bits [7:4] must be 4'b1010. With ADDR_W=9, bit 1 is address bit 8 and bits [3:2] must equal strap_i[2:1]. In general, the lowest ADDR_W-8 of bits [3:1] are address bits and the rest are compared with the strap pins. Bit 0 selects read when 1 and write when 0.
- R3: The acknowledge is sda_oe_o held high across the ninth clock pulse. It is given after a matching select byte, after the word address, and after each accepted data byte, and it is released after that pulse.
- R4: A select byte that does not match is not acknowledged, and every following byte is ignored until the next START.
- R5: While busy_i is high, a matching select byte is not acknowledged. Once busy_i is low, it is acknowledged again.
- R6: Each accepted data byte produces a one-cycle wr_en_o with wr_addr_o and wr_data_o. The address then increments in its low PAGE_W bits only (16-byte page wrap), so an 18-byte burst overwrites the first two bytes of the page.
- R7: A STOP that follows at least one accepted data byte pulses commit_o for one cycle. A STOP with no accepted data does not.
- R8: With wp_i high, the select byte and the word address are acknowledged, but the first data byte is not. No wr_en_o or commit_o follows, and the array keeps its old value.
- R9: A read shifts out eight bits MSB first. A master acknowledge fetches the next byte. A master no-acknowledge ends the transfer with sda_oe_o released.
- R10: The address counter holds the last accessed address plus one, so a read without a new address starts there. A write of the word address followed by a repeated START with read set reads from that address.
- R11: Sequential reads increment the full address and wrap from 2^ADDR_W-1 to 0.
- R12: sda_oe_o changes only in the cycle after a detected clock fall, START or STOP, never in the middle of a clock-high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| strap_i | input | 3 | Device strap pins compared with select bits [3:1] |
| wp_i | input | 1 | Write protect, blocks data acceptance |
| busy_i | input | 1 | Array programming cycle in progress |
| wr_en_o | output | 1 | One-cycle write into the page buffer |
| wr_addr_o | output | ADDR_W | Page buffer write address |
| wr_data_o | output | 8 | Page buffer write data |
| commit_o | output | 1 | Start of the array programming cycle |
| rd_addr_o | output | ADDR_W | Array read address |
| rd_data_i | input | 8 | Array read data, combinational from rd_addr_o |

## Verification
The assertions check on every cycle that the pull-low enable moves only right after a clock fall or a bus condition. They also check that a commit follows a STOP, that no write strobe escapes while write protect is set, that no select acknowledge is decided while busy, and that page increments keep the upper address bits. Only the bench scenarios can show the byte-level protocol: which of all 128 write select bytes are acknowledged, the page wrap over an 18-byte burst, the counter carrying over between transfers, the full-range read wrap, and busy polling until the array is free.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SEL, ST_SEL_ACK, ST_WADDR, ST_WADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } ctl_state_e;

  localparam logic [3:0] SEL_PREFIX = 4'b1010;

  // number of select bits that carry memory address instead of strap value
  function automatic int unsigned hi_bits(int unsigned aw);
    return (aw > 8) ? aw - 8 : 0;
  endfunction
endpackage

// File: rtl/i2c_mem_line_sync.sv
module i2c_mem_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o
);
  // [0],[1] synchronizer, [2] previous synchronized sample
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign sda_o      = sda_q[1];
  assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/i2c_mem_addr_ctr.sv
module i2c_mem_addr_ctr #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_page_i,
  input  logic              inc_full_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned PW = (PAGE_W < ADDR_W) ? PAGE_W : ADDR_W;

  logic [ADDR_W-1:0] addr_q, page_next;

  generate
    if (PW == ADDR_W) begin : g_flat
      assign page_next = addr_q + ADDR_W'(1);
    end else begin : g_page
      assign page_next = {addr_q[ADDR_W-1:PW], addr_q[PW-1:0] + PW'(1)};

      // R6
      page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_page_i && !load_i && !inc_full_i) |=>
          (addr_q[ADDR_W-1:PW] == $past(addr_q[ADDR_W-1:PW])));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_q <= '0;
    else if (load_i)     addr_q <= load_val_i;
    else if (inc_full_i) addr_q <= addr_q + ADDR_W'(1);
    else if (inc_page_i) addr_q <= page_next;
  end

  assign addr_o = addr_q;

  // R11
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_full_i && !load_i && (&addr_q)) |=> (addr_q == '0));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  localparam int unsigned HI_N = hi_bits(ADDR_W);
  localparam int unsigned HI_W = (HI_N > 0) ? HI_N : 1;

  logic scl_rise, scl_fall, sda_s, start_det, stop_det;

  i2c_mem_line_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .sda_o(sda_s),
    .start_o(start_det), .stop_o(stop_det)
  );

  ctl_state_e        state_q;
  logic [2:0]        bit_cnt_q;
  logic [6:0]        sh_q;
  logic [7:0]        tx_q, rx_byte, wr_data_q;
  logic [HI_W-1:0]   sel_hi_q;
  logic              ack_q, ack_ph_q, rw_q, oe_q, wr_pend_q, wr_en_q, commit_q;
  logic [ADDR_W-1:0] addr, load_val, wr_addr_q;
  logic              sel_match, byte_end, ld_addr, wr_take, rd_take;

  assign rx_byte = {sh_q, sda_s};

  always_comb begin
    sel_match = (rx_byte[7:4] == SEL_PREFIX);
    for (int i = 0; i < 3; i++) begin
      if (i >= int'(HI_N) && rx_byte[i+1] != strap_i[i]) sel_match = 1'b0;
    end
  end

  generate
    if (HI_N > 0) begin : g_hi
      assign load_val = {sel_hi_q[HI_N-1:0], rx_byte};
    end else begin : g_lo
      assign load_val = rx_byte[ADDR_W-1:0];
    end
  endgenerate

  assign byte_end = scl_rise && (bit_cnt_q == 3'd7);
  assign ld_addr  = byte_end && (state_q == ST_WADDR);
  assign wr_take  = byte_end && (state_q == ST_WDATA) && !wp_i;
  assign rd_take  = scl_fall && ack_ph_q &&
                    ((state_q == ST_SEL_ACK && rw_q) || state_q == ST_RACK);

  i2c_mem_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk_i, .rst_ni,
    .load_i(ld_addr), .load_val_i(load_val),
    .inc_page_i(wr_take), .inc_full_i(rd_take),
    .addr_o(addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      sel_hi_q  <= '0;
      ack_q     <= 1'b0;
      ack_ph_q  <= 1'b0;
      rw_q      <= 1'b0;
      oe_q      <= 1'b0;
      wr_pend_q <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      commit_q  <= 1'b0;
    end else begin
      wr_en_q  <= wr_take;
      commit_q <= stop_det && wr_pend_q;
      if (wr_take) begin
        wr_addr_q <= addr;
        wr_data_q <= rx_byte;
        wr_pend_q <= 1'b1;
      end
      if (start_det) begin
        state_q   <= ST_SEL;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
        ack_ph_q  <= 1'b0;
      end else if (stop_det) begin
        state_q   <= ST_IDLE;
        oe_q      <= 1'b0;
        ack_ph_q  <= 1'b0;
        wr_pend_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_SEL, ST_WADDR, ST_WDATA: if (scl_rise) begin
            sh_q      <= rx_byte[6:0];
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
              unique case (state_q)
                ST_SEL: begin
                  state_q  <= ST_SEL_ACK;
                  ack_q    <= sel_match && !busy_i;
                  rw_q     <= rx_byte[0];
                  sel_hi_q <= rx_byte[HI_W:1];
                end
                ST_WADDR: begin
                  state_q <= ST_WADDR_ACK;
                  ack_q   <= 1'b1;
                end
                default: begin
                  state_q <= ST_WDATA_ACK;
                  ack_q   <= !wp_i;
                end
              endcase
            end
          end
          ST_SEL_ACK, ST_WADDR_ACK, ST_WDATA_ACK: if (scl_fall) begin
            if (!ack_ph_q) begin
              if (ack_q) begin
                oe_q     <= 1'b1;
                ack_ph_q <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              ack_ph_q  <= 1'b0;
              bit_cnt_q <= '0;
              if (state_q == ST_SEL_ACK && rw_q) begin
                state_q <= ST_RDATA;
                tx_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
              end else begin
                oe_q    <= 1'b0;
                state_q <= (state_q == ST_SEL_ACK) ? ST_WADDR : ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 3'd1;
              if (bit_cnt_q == 3'd7) state_q <= ST_RACK;
            end else if (scl_fall) begin
              oe_q <= ~tx_q[~bit_cnt_q];
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_s) state_q <= ST_IDLE;
              else       ack_ph_q <= 1'b1;
            end else if (scl_fall) begin
              if (!ack_ph_q) begin
                oe_q <= 1'b0;
              end else begin
                ack_ph_q  <= 1'b0;
                bit_cnt_q <= '0;
                tx_q      <= rd_data_i;
                oe_q      <= ~rd_data_i[7];
                state_q   <= ST_RDATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign commit_o  = commit_q;
  assign rd_addr_o = addr;

  // R12
  oe_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> $past(scl_fall || start_det || stop_det));

  // R7
  commit_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_det));

  // R8
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(!wp_i));

  // R5
  busy_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEL && byte_end && busy_i && !start_det && !stop_det) |=> !ack_q);
endmodule

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb_top;
  localparam int AW = 9;
  localparam int Q = 5;
  localparam int BUSY_LEN = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wp = 1'b0, busy;
  logic [2:0] strap = 3'b110;
  logic wr_en, commit;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_mem_slave #(.ADDR_W(AW), .PAGE_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .wp_i(wp), .busy_i(busy),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .commit_o(commit),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // array model with page buffer and programming timer
  logic [7:0] mem [1 << AW];
  logic [7:0] pbuf [1 << AW];
  logic       pval [1 << AW];
  logic [7:0] expm [1 << AW];
  int busy_cnt = 0, wr_cnt = 0, commit_cnt = 0, oe_viol = 0, scl_hi = 0;
  logic prev_oe = 1'b0;
  int checks = 0, fails = 0;

  assign busy    = (busy_cnt != 0);
  assign rd_data = mem[rd_addr];

  initial begin
    for (int a = 0; a < (1 << AW); a++) begin
      mem[a] = pat(a); expm[a] = pat(a); pval[a] = 1'b0; pbuf[a] = '0;
    end
  end

  always @(posedge clk) begin
    if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (wr_en) begin
      pbuf[wr_addr] <= wr_data; pval[wr_addr] <= 1'b1; wr_cnt <= wr_cnt + 1;
    end
    if (commit) begin
      for (int a = 0; a < (1 << AW); a++) begin
        if (pval[a]) mem[a] <= pbuf[a];
        pval[a] <= 1'b0;
      end
      busy_cnt <= BUSY_LEN;
      commit_cnt <= commit_cnt + 1;
    end
    scl_hi <= scl_m ? scl_hi + 1 : 0;
    if (rst_n && prev_oe != sda_oe && scl_hi > 4) oe_viol <= oe_viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(nb);
    ack = !nb;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(!mack);
  endtask

  task automatic wait_free();
    while (busy) tick(1);
    tick(2);
  endtask

  // write word address then repeated START for read
  task automatic set_read(input int a, input string req);
    logic ack;
    bus_start();
    send_byte({4'hA, strap[2:1], a[8], 1'b0}, ack); chk(req, "dummy sel ack", ack, 1);
    send_byte(a[7:0], ack);                          chk(req, "word ack", ack, 1);
    bus_start();
    send_byte({4'hA, strap[2:1], 1'b0, 1'b1}, ack);  chk(req, "read sel ack", ack, 1);
  endtask

  initial begin
    tick(4);
    // R1 reset state
    chk("R1", "sda_oe after reset", sda_oe, 0);
    chk("R1", "wr_en after reset", wr_en, 0);
    rst_n = 1'b1;
    tick(4);
    chk("R1", "commit idle", commit, 0);
  end

  initial begin : main
    logic ack;
    logic [7:0] v;
    int w0, c0, tries;
    tick(12);

    // R3 R6 R7 byte write to 0x123
    w0 = wr_cnt; c0 = commit_cnt;
    bus_start();
    send_byte(8'hAE, ack); chk("R3", "select ack", ack, 1);
    send_byte(8'h23, ack); chk("R3", "word ack", ack, 1);
    send_byte(8'h5C, ack); chk("R3", "data ack", ack, 1);
    tick(2);
    chk("R3", "release after ack", sda_oe, 0);
    bus_stop();
    tick(4);
    expm[9'h123] = 8'h5C;
    chk("R6", "one write strobe", wr_cnt - w0, 1);
    chk("R7", "commit after stop", commit_cnt - c0, 1);

    // R5 polling while busy
    bus_start();
    send_byte(8'hAE, ack); chk("R5", "nack while busy", ack, 0);
    bus_stop();
    tries = 0; ack = 1'b0;
    while (!ack && tries < 20) begin
      bus_start(); send_byte(8'hAE, ack); bus_stop(); tries++;
    end
    chk("R5", "ack after busy ends", ack, 1);
    chk("R7", "no commit without data", commit_cnt - c0, 1);

    // R10 random read then immediate read
    set_read(9'h123, "R10");
    recv_byte(v, 1'b0); bus_stop();
    chk("R10", "random read 0x123", v, expm[9'h123]);
    chk("R9", "released after nack", sda_oe, 0);
    bus_start();
    send_byte(8'hAF, ack); chk("R10", "current read sel ack", ack, 1);
    recv_byte(v, 1'b0); bus_stop();
    chk("R10", "current read 0x124", v, expm[9'h124]);

    // R9 R11 sequential read across top address
    set_read(9'h1FE, "R11");
    for (int k = 0; k < 4; k++) begin
      recv_byte(v, k != 3);
      chk("R11", "sequential byte", v, expm[(9'h1FE + k) & 9'h1FF]);
    end
    bus_stop();
    chk("R9", "line free after last", sda_oe, 0);

    // R1 START in the middle of a byte
    bus_start();
    for (int i = 7; i >= 4; i--) put_bit(v[i] ^ 1'b1);
    bus_start();
    send_byte(8'hAC, ack); chk("R1", "select after restart", ack, 1);
    bus_stop();
    send_byte(8'hAC, ack); chk("R1", "no ack without start", ack, 0);
    bus_stop();

    // R6 page write 18 bytes from 0x020
    w0 = wr_cnt;
    bus_start();
    send_byte(8'hAC, ack);
    send_byte(8'h20, ack);
    for (int i = 0; i < 18; i++) begin
      send_byte(8'(8'hC0 + i), ack);
      chk("R6", "page data ack", ack, 1);
      expm[9'h20 + (i & 15)] = 8'(8'hC0 + i);
    end
    bus_stop();
    tick(4);
    chk("R6", "page strobes", wr_cnt - w0, 18);
    wait_free();
    set_read(9'h020, "R6");
    for (int k = 0; k < 17; k++) begin
      recv_byte(v, k != 16);
      chk("R6", "page readback", v, expm[9'h20 + k]);
    end
    bus_stop();

    // R8 write protect
    wp = 1'b1; w0 = wr_cnt; c0 = commit_cnt;
    bus_start();
    send_byte(8'hAC, ack); chk("R8", "sel ack under wp", ack, 1);
    send_byte(8'h50, ack); chk("R8", "word ack under wp", ack, 1);
    send_byte(8'h99, ack); chk("R8", "data nack under wp", ack, 0);
    bus_stop();
    tick(4);
    chk("R8", "no strobe", wr_cnt - w0, 0);
    chk("R8", "no commit", commit_cnt - c0, 0);
    wp = 1'b0;
    set_read(9'h050, "R8");
    recv_byte(v, 1'b0); bus_stop();
    chk("R8", "array unchanged", v, expm[9'h050]);

    // R4 strap mismatch then ignored byte
    w0 = wr_cnt;
    bus_start();
    send_byte(8'hA6, ack); chk("R4", "mismatch nack", ack, 0);
    send_byte(8'h10, ack); chk("R4", "following byte ignored", ack, 0);
    send_byte(8'h77, ack); chk("R4", "data ignored", ack, 0);
    bus_stop();
    tick(4);
    chk("R4", "no strobe", wr_cnt - w0, 0);

    // R2 sweep of all write select bytes
    for (int s = 0; s < 128; s++) begin
      logic [7:0] sel;
      sel = {s[6:0], 1'b0};
      bus_start();
      send_byte(sel, ack);
      bus_stop();
      chk("R2", $sformatf("select %02h", sel), ack,
          (sel[7:4] == 4'hA && sel[3:2] == strap[2:1]) ? 1 : 0);
    end

    chk("R12", "oe change in clock high", oe_viol, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule